// File: doc/BRIEF.md
# Channel Program Sequencer

This block is a small input/output channel engine. The host processor hands it one start command that carries only two things: the memory address where a channel program begins and the number of the device to serve. The sequencer then reads the program out of main memory, which it shares with the processor and reaches through a request/grant port, and runs it one command at a time. Each command moves a block of words between the chosen device and a contiguous memory area, or sends one control word to the device.

Each command carries its own memory address, transfer count, last-command flag and end-of-record flag. A single start can therefore scatter or gather several blocks across different memory areas and mark record boundaries towards the device. The processor sees one interrupt, when the program finishes or when the sequencer aborts it because a command is malformed.

Top module: `chanseq_top`

## Requirements
- R1: A start pulse is accepted only while `busy_o` is low. `busy_o` rises on the next cycle. A start pulse while busy has no effect on the running program.
- R2: Every command occupies two consecutive memory words. The first word has the opcode in bits [31:29], the last-command flag in bit 28, the end-of-record flag in bit 27 and the transfer count in bits [15:0]. The second word holds the memory address. The next command is read at the current command's address plus 2.
- R3: Opcode 1 (device to memory) takes `count` words from the selected device in order and writes them to consecutive addresses starting at the command's address. No other address is written.
- R4: Opcode 2 (memory to device) reads `count` consecutive words starting at the command's address and delivers them to the selected device in address order.
- R5: Opcode 3 (control) makes exactly one control transfer to the selected device. During that transfer `dev_ctrl_o` is high and `dev_wdata_o` carries the command's address word, zero-extended.
- R6: When a command whose end-of-record flag is 1 completes, the selected device gets a one-cycle `dev_rec_end_o` pulse. A command with the flag at 0 produces no pulse.
- R7: After the command with the last-command flag set completes, the sequencer goes idle, raises `done_o` and pulses `irq_o` for one cycle. No interrupt occurs between commands.
- R8: An opcode outside 1..3, or a count of zero, aborts the program before that command transfers anything. On abort `err_o` is set, `done_o` stays low, and `irq_o` pulses once.
- R9: Only the device named in the start command sees select, handshake or record-end activity. All other devices' lines stay low.
- R10: A memory request stays asserted, with address, write-enable and write data unchanged, until it is granted. Read data is taken on the cycle after the grant.
- R11: `done_o` and `err_o` hold their value until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse from the processor |
| start_addr_i | input | AW | Address of the first command word |
| start_dev_i | input | DEVW | Device number to serve |
| busy_o | output | 1 | Program running |
| irq_o | output | 1 | One-cycle interrupt at completion or abort |
| done_o | output | 1 | Last program ended normally |
| err_o | output | 1 | Last program aborted |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | DW | Read data, valid the cycle after grant |
| dev_sel_o | output | NDEV | Active device select |
| dev_rready_o | output | NDEV | Sequencer ready for a word from the device |
| dev_rvalid_i | input | NDEV | Device offers a word |
| dev_rdata_i | input | NDEV*DW | Per-device data words, device k at bits [k*DW +: DW] |
| dev_wvalid_o | output | NDEV | Data word offered to the device |
| dev_ctrl_o | output | NDEV | Control word offered to the device |
| dev_wready_i | input | NDEV | Device accepts the offered word |
| dev_wdata_o | output | DW | Data or control word to the device |
| dev_rec_end_o | output | NDEV | End-of-record pulse |

## Verification
The bench sweeps every device number, counts from 1 to 4 and both free and stalled memory and device handshakes. It checks word-exact memory images around the target areas, so a design that loses the final transfer or writes one word past the block would show a wrong or extra word. It walks every undefined opcode and the zero count. An abort that still moved a word would show up in the device logs, and a missing error flag or a doubled interrupt is counted. It also fires a second start mid-program, which a sequencer that reloaded its pointer would visibly obey.

// File: rtl/chanseq_pkg.sv
package chanseq_pkg;

    typedef enum logic [1:0] {
        K_DEV2MEM = 2'd0,
        K_MEM2DEV = 2'd1,
        K_CONTROL = 2'd2,
        K_INVALID = 2'd3
    } kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_FWAIT,
        S_DEV_IN,
        S_MEM_WR,
        S_MEM_RD,
        S_MEM_RWAIT,
        S_DEV_OUT,
        S_CTRL,
        S_CMD_END
    } state_e;

    localparam logic [2:0] OPC_DEV2MEM = 3'd1;
    localparam logic [2:0] OPC_MEM2DEV = 3'd2;
    localparam logic [2:0] OPC_CONTROL = 3'd3;

endpackage

// File: rtl/chanseq_cmd_decode.sv
module chanseq_cmd_decode
    import chanseq_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic [DW-1:0] word_i,
    output kind_e         kind_o,
    output logic          last_o,
    output logic          rec_end_o,
    output logic [CW-1:0] count_o,
    output logic          illegal_o
);
    localparam int OP_LSB = DW - 3;
    localparam int P_BIT  = DW - 4;
    localparam int R_BIT  = DW - 5;

    logic [2:0] opc;

    always_comb begin
        opc       = word_i[DW-1:OP_LSB];
        last_o    = word_i[P_BIT];
        rec_end_o = word_i[R_BIT];
        count_o   = word_i[CW-1:0];
        unique case (opc)
            OPC_DEV2MEM: kind_o = K_DEV2MEM;
            OPC_MEM2DEV: kind_o = K_MEM2DEV;
            OPC_CONTROL: kind_o = K_CONTROL;
            default:     kind_o = K_INVALID;
        endcase
        illegal_o = (kind_o == K_INVALID) || (count_o == '0);
    end
endmodule

// File: rtl/chanseq_dev_port.sv
module chanseq_dev_port #(
    parameter int NDEV = 4,
    parameter int DW   = 32,
    localparam int DEVW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic [DEVW-1:0]   dev_i,
    input  logic              want_in_i,
    input  logic              offer_data_i,
    input  logic              offer_ctrl_i,
    input  logic              rec_end_i,
    input  logic [NDEV-1:0]   dev_rvalid_i,
    input  logic [NDEV*DW-1:0] dev_rdata_i,
    input  logic [NDEV-1:0]   dev_wready_i,
    output logic [NDEV-1:0]   dev_sel_o,
    output logic [NDEV-1:0]   dev_rready_o,
    output logic [NDEV-1:0]   dev_wvalid_o,
    output logic [NDEV-1:0]   dev_ctrl_o,
    output logic [NDEV-1:0]   dev_rec_end_o,
    output logic              sel_rvalid_o,
    output logic [DW-1:0]     sel_rdata_o,
    output logic              sel_wready_o
);
    for (genvar g = 0; g < NDEV; g++) begin : g_lane
        logic hit;
        assign hit              = active_i && (dev_i == DEVW'(g));
        assign dev_sel_o[g]     = hit;
        assign dev_rready_o[g]  = hit && want_in_i;
        assign dev_wvalid_o[g]  = hit && offer_data_i;
        assign dev_ctrl_o[g]    = hit && offer_ctrl_i;
        assign dev_rec_end_o[g] = (dev_i == DEVW'(g)) && rec_end_i;
    end

    always_comb begin
        sel_rvalid_o = dev_rvalid_i[dev_i];
        sel_wready_o = dev_wready_i[dev_i];
        sel_rdata_o  = dev_rdata_i[int'(dev_i)*DW +: DW];
    end

    // R9: at most one lane selected, one record-end pulse
    p_one_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel_o));
    p_rec_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_rec_end_o));
    // R9: handshakes only on the selected lane
    p_hs_in_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_rready_o | dev_wvalid_o | dev_ctrl_o) & ~dev_sel_o) == '0);
endmodule

// File: rtl/chanseq_top.sv
module chanseq_top
    import chanseq_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int CW   = 16,
    parameter int NDEV = 4,
    localparam int DEVW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [AW-1:0]      start_addr_i,
    input  logic [DEVW-1:0]    start_dev_i,
    output logic               busy_o,
    output logic               irq_o,
    output logic               done_o,
    output logic               err_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [AW-1:0]      mem_addr_o,
    output logic [DW-1:0]      mem_wdata_o,
    input  logic               mem_gnt_i,
    input  logic [DW-1:0]      mem_rdata_i,
    output logic [NDEV-1:0]    dev_sel_o,
    output logic [NDEV-1:0]    dev_rready_o,
    input  logic [NDEV-1:0]    dev_rvalid_i,
    input  logic [NDEV*DW-1:0] dev_rdata_i,
    output logic [NDEV-1:0]    dev_wvalid_o,
    output logic [NDEV-1:0]    dev_ctrl_o,
    input  logic [NDEV-1:0]    dev_wready_i,
    output logic [DW-1:0]      dev_wdata_o,
    output logic [NDEV-1:0]    dev_rec_end_o
);
    localparam int ADDR_COPY = (AW < DW) ? AW : DW;

    typedef struct packed {
        state_e            st;
        logic [AW-1:0]     pc;
        logic              half;
        logic [DW-1:0]     w0;
        logic [AW-1:0]     addr;
        logic [CW-1:0]     cnt;
        logic [DEVW-1:0]   dev;
        logic [DW-1:0]     dbuf;
        logic              done;
        logic              err;
        logic              irq;
        logic              recend;
    } regs_t;

    regs_t q, d;

    kind_e          cmd_kind;
    logic           cmd_last;
    logic           cmd_rec;
    logic [CW-1:0]  cmd_count;
    logic           cmd_illegal;

    logic           want_in, offer_data, offer_ctrl;
    logic           sel_rvalid, sel_wready;
    logic [DW-1:0]  sel_rdata;

    chanseq_cmd_decode #(.DW(DW), .CW(CW)) u_decode (
        .word_i    (q.w0),
        .kind_o    (cmd_kind),
        .last_o    (cmd_last),
        .rec_end_o (cmd_rec),
        .count_o   (cmd_count),
        .illegal_o (cmd_illegal)
    );

    chanseq_dev_port #(.NDEV(NDEV), .DW(DW)) u_devport (
        .clk           (clk),
        .rst_n         (rst_n),
        .active_i      (busy_o),
        .dev_i         (q.dev),
        .want_in_i     (want_in),
        .offer_data_i  (offer_data),
        .offer_ctrl_i  (offer_ctrl),
        .rec_end_i     (q.recend),
        .dev_rvalid_i  (dev_rvalid_i),
        .dev_rdata_i   (dev_rdata_i),
        .dev_wready_i  (dev_wready_i),
        .dev_sel_o     (dev_sel_o),
        .dev_rready_o  (dev_rready_o),
        .dev_wvalid_o  (dev_wvalid_o),
        .dev_ctrl_o    (dev_ctrl_o),
        .dev_rec_end_o (dev_rec_end_o),
        .sel_rvalid_o  (sel_rvalid),
        .sel_rdata_o   (sel_rdata),
        .sel_wready_o  (sel_wready)
    );

    always_comb begin
        d          = q;
        d.irq      = 1'b0;
        d.recend   = 1'b0;
        mem_req_o  = 1'b0;
        mem_we_o   = 1'b0;
        mem_addr_o = q.addr;
        mem_wdata_o = q.dbuf;
        want_in    = 1'b0;
        offer_data = 1'b0;
        offer_ctrl = 1'b0;
        dev_wdata_o = q.dbuf;

        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.pc   = start_addr_i;
                    d.dev  = start_dev_i;
                    d.half = 1'b0;
                    d.done = 1'b0;
                    d.err  = 1'b0;
                    d.st   = S_FETCH;
                end
            end
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.pc + AW'(q.half);
                if (mem_gnt_i) d.st = S_FWAIT;
            end
            S_FWAIT: begin
                if (!q.half) begin
                    d.w0   = mem_rdata_i;
                    d.half = 1'b1;
                    d.st   = S_FETCH;
                end else begin
                    d.half = 1'b0;
                    d.addr = mem_rdata_i[AW-1:0];
                    d.cnt  = cmd_count;
                    if (cmd_illegal) begin
                        d.err = 1'b1;
                        d.irq = 1'b1;
                        d.st  = S_IDLE;
                    end else begin
                        unique case (cmd_kind)
                            K_DEV2MEM: d.st = S_DEV_IN;
                            K_MEM2DEV: d.st = S_MEM_RD;
                            default:   d.st = S_CTRL;
                        endcase
                    end
                end
            end
            S_DEV_IN: begin
                want_in = 1'b1;
                if (sel_rvalid) begin
                    d.dbuf = sel_rdata;
                    d.st   = S_MEM_WR;
                end
            end
            S_MEM_WR: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                if (mem_gnt_i) begin
                    d.addr = q.addr + AW'(1);
                    d.cnt  = q.cnt - CW'(1);
                    d.st   = (q.cnt == CW'(1)) ? S_CMD_END : S_DEV_IN;
                end
            end
            S_MEM_RD: begin
                mem_req_o = 1'b1;
                if (mem_gnt_i) d.st = S_MEM_RWAIT;
            end
            S_MEM_RWAIT: begin
                d.dbuf = mem_rdata_i;
                d.st   = S_DEV_OUT;
            end
            S_DEV_OUT: begin
                offer_data = 1'b1;
                if (sel_wready) begin
                    d.addr = q.addr + AW'(1);
                    d.cnt  = q.cnt - CW'(1);
                    d.st   = (q.cnt == CW'(1)) ? S_CMD_END : S_MEM_RD;
                end
            end
            S_CTRL: begin
                offer_ctrl  = 1'b1;
                dev_wdata_o = '0;
                dev_wdata_o[ADDR_COPY-1:0] = q.addr[ADDR_COPY-1:0];
                if (sel_wready) d.st = S_CMD_END;
            end
            S_CMD_END: begin
                d.recend = cmd_rec;
                if (cmd_last) begin
                    d.done = 1'b1;
                    d.irq  = 1'b1;
                    d.st   = S_IDLE;
                end else begin
                    d.pc = q.pc + AW'(2);
                    d.st = S_FETCH;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != S_IDLE);
    assign irq_o  = q.irq;
    assign done_o = q.done;
    assign err_o  = q.err;

    // R1: an accepted start makes the block busy on the next cycle
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);
    // R1: a start while busy does not change the served device
    p_busy_keep_dev_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(q.dev));
    // R10: pending request holds its attributes
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
    // R7: interrupt is a single-cycle pulse seen only once idle
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !busy_o);
    // R8: an abort is always accompanied by the interrupt
    p_err_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> irq_o);
    // R3: transfer states never run with an exhausted count
    p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st inside {S_DEV_IN, S_MEM_WR, S_MEM_RD, S_MEM_RWAIT, S_DEV_OUT}) |-> (q.cnt != '0));
    // R11: status flags move only when a start is accepted or the program ends
    p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(done_o) && $stable(err_o)));
endmodule

// File: tb/chanseq_top_tb.sv
module chanseq_top_tb;
    localparam int AW = 16, DW = 32, CW = 16, NDEV = 4, DEVW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [DEVW-1:0] start_dev_i = '0;
    logic busy_o, irq_o, done_o, err_o;
    logic mem_req_o, mem_we_o, mem_gnt_i;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o, mem_rdata_i, dev_wdata_o;
    logic [NDEV-1:0] dev_sel_o, dev_rready_o, dev_rvalid_i, dev_wvalid_o, dev_ctrl_o, dev_wready_i, dev_rec_end_o;
    logic [NDEV*DW-1:0] dev_rdata_i;

    chanseq_top #(.AW(AW), .DW(DW), .CW(CW), .NDEV(NDEV)) u_dut (.*);

    int vectors = 0, errors = 0;
    logic stall = 1'b0;
    logic tog = 1'b0;
    logic [DW-1:0] mem [256];
    logic [DW-1:0] rd_q = '0;
    int src_idx [NDEV];
    int rec_cnt [NDEV];
    int irq_cnt = 0;
    int sink_n = 0;
    logic [DW-1:0] sink_data [64];
    int sink_dev [64];
    logic sink_ctrl [64];

    function automatic logic [DW-1:0] devword(int dv, int i);
        return 32'hA500_0000 | (dv << 16) | (i & 16'hFFFF);
    endfunction
    // opcode [31:29], last [28], record end [27], count [15:0]
    function automatic logic [DW-1:0] cw0(int op, bit p, bit r, int cnt);
        return {3'(op), p, r, 11'd0, 16'(cnt)};
    endfunction

    assign mem_gnt_i   = stall ? tog : 1'b1;
    assign mem_rdata_i = rd_q;
    always_comb begin
        for (int k = 0; k < NDEV; k++) begin
            dev_rdata_i[k*DW +: DW] = devword(k, src_idx[k]);
            dev_rvalid_i[k] = stall ? ~tog : 1'b1;
            dev_wready_i[k] = stall ? ~tog : 1'b1;
        end
    end

    initial for (int k = 0; k < NDEV; k++) begin src_idx[k] = 0; rec_cnt[k] = 0; end

    always @(posedge clk) begin
        tog <= ~tog;
        if (mem_req_o && mem_gnt_i) begin
            if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
            else rd_q <= mem[mem_addr_o[7:0]];
        end
        if (irq_o) irq_cnt <= irq_cnt + 1;
        for (int k = 0; k < NDEV; k++) begin
            if (dev_rready_o[k] && dev_rvalid_i[k]) src_idx[k] <= src_idx[k] + 1;
            if (dev_rec_end_o[k]) rec_cnt[k] <= rec_cnt[k] + 1;
            if ((dev_wvalid_o[k] || dev_ctrl_o[k]) && dev_wready_i[k]) begin
                sink_data[sink_n % 64] <= dev_wdata_o;
                sink_dev[sink_n % 64]  <= k;
                sink_ctrl[sink_n % 64] <= dev_ctrl_o[k];
                sink_n <= sink_n + 1;
            end
        end
    end

    task automatic chk(bit ok, string req, longint act, longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int cyc = 0;
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    task automatic launch(int addr, int dv);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = AW'(addr); start_dev_i = DEVW'(dv);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_irq(int base_irq);
        int t = 0;
        while (irq_cnt == base_irq && t < 3000) begin @(negedge clk); t++; end
        @(negedge clk); @(negedge clk);
    endtask

    int s0, i0, r0 [NDEV], sx [NDEV];
    task automatic snap();
        s0 = sink_n; i0 = irq_cnt;
        for (int k = 0; k < NDEV; k++) begin r0[k] = rec_cnt[k]; sx[k] = src_idx[k]; end
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        // reset state
        chk(!busy_o && !irq_o && !done_o && !err_o, "R7 reset flags", {busy_o, irq_o, done_o, err_o}, 0);
        chk(dev_sel_o == 0 && !mem_req_o, "R9 reset idle lines", dev_sel_o, 0);
        rst_n = 1'b1;

        // main sweep: device x count x stall
        for (int sm = 0; sm < 2; sm++) begin
            for (int dv = 0; dv < NDEV; dv++) begin
                for (int n = 1; n <= 4; n++) begin
                    int pb = sm ? 8'h10 : 8'h00;
                    stall = 1'(sm);
                    mem[pb+0] = cw0(1, 0, 0, n); mem[pb+1] = 32'h40;
                    mem[pb+2] = cw0(2, 0, 1, n); mem[pb+3] = 32'h80;
                    mem[pb+4] = cw0(3, 1, 1, 1); mem[pb+5] = 32'h1230 + dv;
                    for (int k = 0; k < 8; k++) begin
                        mem[8'h40+k] = '0;
                        mem[8'h80+k] = 32'hB000_0000 | (sm << 12) | (dv << 8) | (n << 4) | k;
                    end
                    @(negedge clk);
                    snap();
                    launch(pb, dv);
                    wait_irq(i0);
                    for (int k = 0; k < n; k++)
                        chk(mem[8'h40+k] == devword(dv, sx[dv]+k), "R3 stored word", mem[8'h40+k], devword(dv, sx[dv]+k));
                    chk(mem[8'h40+n] == 0, "R3 no overrun", mem[8'h40+n], 0);
                    chk(sink_n - s0 == n + 1, "R4 device transfer count", sink_n - s0, n + 1);
                    for (int k = 0; k < n; k++) begin
                        logic [DW-1:0] ex;
                        ex = 32'hB000_0000 | (sm << 12) | (dv << 8) | (n << 4) | k;
                        chk(sink_data[(s0+k)%64] == ex && !sink_ctrl[(s0+k)%64] && sink_dev[(s0+k)%64] == dv,
                            "R4 delivered word", sink_data[(s0+k)%64], ex);
                    end
                    chk(sink_ctrl[(s0+n)%64] && sink_data[(s0+n)%64] == 32'h1230 + dv && sink_dev[(s0+n)%64] == dv,
                        "R5 control word", sink_data[(s0+n)%64], 32'h1230 + dv);
                    chk(rec_cnt[dv] - r0[dv] == 2, "R6 record ends", rec_cnt[dv] - r0[dv], 2);
                    for (int k = 0; k < NDEV; k++) if (k != dv) begin
                        chk(rec_cnt[k] == r0[k] && src_idx[k] == sx[k], "R9 idle device untouched", src_idx[k] - sx[k], 0);
                    end
                    chk(irq_cnt - i0 == 1, "R7 single interrupt", irq_cnt - i0, 1);
                    chk(done_o && !err_o && !busy_o, "R7 done flags (R2 chaining, R11)", {done_o, err_o, busy_o}, 3'b100);
                end
            end
        end

        // bad opcodes after a good command
        stall = 1'b0;
        for (int op = 0; op < 8; op++) begin
            if (op >= 1 && op <= 3) continue;
            mem[0] = cw0(1, 0, 0, 2); mem[1] = 32'h40;
            mem[2] = cw0(op, 1, 1, 3); mem[3] = 32'h80;
            for (int k = 0; k < 4; k++) mem[8'h40+k] = '0;
            @(negedge clk); snap();
            launch(0, 1);
            wait_irq(i0);
            chk(err_o && !done_o, "R8 abort flags", {err_o, done_o}, 2'b10);
            chk(irq_cnt - i0 == 1, "R8 abort interrupt", irq_cnt - i0, 1);
            chk(mem[8'h41] == devword(1, sx[1]+1) && mem[8'h42] == 0, "R8 earlier command kept", mem[8'h41], devword(1, sx[1]+1));
            chk(sink_n == s0 && rec_cnt[1] == r0[1], "R8 aborted command idle", sink_n - s0, 0);
        end

        // zero count aborts
        mem[0] = cw0(2, 1, 1, 0); mem[1] = 32'h80;
        @(negedge clk); snap();
        launch(0, 2);
        wait_irq(i0);
        chk(err_o && sink_n == s0 && src_idx[2] == sx[2], "R8 zero count", {err_o, 1'(sink_n - s0)}, 2'b10);

        // error flag held, then cleared by next start
        repeat (5) @(negedge clk);
        chk(err_o && !done_o, "R11 flag held", err_o, 1);
        mem[0] = cw0(3, 1, 0, 1); mem[1] = 32'h0055;
        mem[8'h20] = cw0(3, 1, 0, 1); mem[8'h21] = 32'h0077;
        @(negedge clk); snap();
        launch(0, 3);
        chk(!err_o && !done_o && busy_o, "R11 cleared on start", {err_o, done_o, busy_o}, 3'b001);
        // second start while busy
        @(negedge clk);
        start_i = 1'b1; start_addr_i = 16'h20; start_dev_i = 2'd0;
        @(negedge clk); start_i = 1'b0;
        wait_irq(i0);
        chk(sink_n - s0 == 1 && sink_data[s0%64] == 32'h55 && sink_dev[s0%64] == 3, "R1 busy start ignored", sink_data[s0%64], 32'h55);
        chk(irq_cnt - i0 == 1 && rec_cnt[3] == r0[3], "R1 one program, R6 no record end", irq_cnt - i0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule